// File: doc/BRIEF.md
# Push-Button Press Qualifier with Release Blanking

This block turns a raw push-button level, arriving with no timing relation to the system clock, into a clean single-cycle pulse for each press that counts. The level first crosses into the clock domain through a short flip-flop chain. A one-cycle delayed copy of the synchronised level is kept, so rising and falling transitions can be seen as a change between consecutive samples.

Mechanical contacts chatter when they open. To keep that chatter from registering as new presses, every release (a high-to-low transition) starts a blanking window, held in a down-counter. A press (a low-to-high transition) is turned into an output pulse only when that counter is already idle. The first contact of a real press is therefore accepted with no settling delay. Chatter that follows a release, or any release that follows a short contact during a press, is blanked instead. A further release inside an open window restarts the window from its full length. The pulse feeds whatever counts or acts on presses, such as a mode stepper or a length counter.

Top module: `btn_press_qualifier`

## Requirements
- R1: While `rst` is high and in the first sample after it falls (with `btn_raw` low), `press_pulse` and `blank_active` are both 0.
- R2: With the window idle, a low-to-high change of `btn_raw` made between clock edges gives `press_pulse` high in the cycle that follows the third rising clock edge after the change, and low in the cycles before it.
- R3: An accepted press gives `press_pulse` high for exactly one cycle. Holding the button high gives no further pulses.
- R4: A high-to-low change of `btn_raw` sets `blank_active` from the third rising clock edge after the change. It then stays high for exactly 2^CNT_W-1 cycles, counting down by one each cycle, and falls to 0.
- R5: A rising transition seen while the blanking counter is nonzero is ignored: `press_pulse` stays 0.
- R6: Take a release and a following press, driven d clock cycles apart. The press gives a pulse if and only if d >= 2^CNT_W.
- R7: A falling transition while the window is still open reloads the counter to all ones. The window then ends 2^CNT_W-1 cycles after the reload, not after the first load.
- R8: A falling transition never produces a `press_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw button level, asynchronous to `clk` |
| press_pulse | output | 1 | One-cycle pulse for each accepted press |
| blank_active | output | 1 | High while the release blanking window is open |

## Verification
The checker takes for granted that reset is held for several cycles at start-up, so the counter and sample registers hold known values before any property is evaluated. It also assumes that `btn_raw` changes at most once per clock period, so the sampled pattern matches the pattern that was driven. The bench changes the button only on falling clock edges and never more than once per cycle. It uses a 4-bit counter, so a window lasts 15 cycles. This lets it sweep every release-to-press spacing from one cycle to past the end of the window.

// File: rtl/bpq_pkg.sv
package bpq_pkg;

  // Transitions found between consecutive synchronised samples
  typedef struct packed {
    logic rise;
    logic fall;
  } bpq_edges_t;

endpackage

// File: rtl/bpq_sync.sv
module bpq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/bpq_edge.sv
module bpq_edge
  import bpq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       level,
  output bpq_edges_t edges
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  always_comb begin
    edges.rise = level & ~prev_q;
    edges.fall = ~level & prev_q;
  end

endmodule

// File: rtl/bpq_blank.sv
module bpq_blank #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             busy
);

  localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= CNT_ZERO;
    else if (restart)           cnt_q <= CNT_FULL;
    else if (cnt_q != CNT_ZERO) cnt_q <= cnt_q - 1'b1;
  end

  assign count = cnt_q;
  assign busy  = (cnt_q != CNT_ZERO);

endmodule

// File: rtl/btn_press_qualifier.sv
module btn_press_qualifier
  import bpq_pkg::*;
#(
  parameter int CNT_W       = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press_pulse,
  output logic blank_active
);

  logic             btn_sync;
  bpq_edges_t       edges;
  logic [CNT_W-1:0] blank_cnt;
  logic             blank_busy;
  logic             pulse_q;
  logic             rise_w;
  logic             fall_w;

  bpq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (btn_raw),
    .dout (btn_sync)
  );

  bpq_edge i_edge (
    .clk   (clk),
    .rst   (rst),
    .level (btn_sync),
    .edges (edges)
  );

  assign rise_w = edges.rise;
  assign fall_w = edges.fall;

  bpq_blank #(.CNT_W(CNT_W)) i_blank (
    .clk     (clk),
    .rst     (rst),
    .restart (fall_w),
    .count   (blank_cnt),
    .busy    (blank_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= rise_w & ~blank_busy;
  end

  assign press_pulse  = pulse_q;
  assign blank_active = blank_busy;

endmodule

// File: rtl/btn_press_qualifier_chk.sv
module btn_press_qualifier_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             press_pulse,
  input logic             blank_active,
  input logic             rise,
  input logic             fall,
  input logic [CNT_W-1:0] cnt
);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse);

  // R5
  no_press_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> !$past(blank_active));

  // R4
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) != '0 && !$past(fall)) |-> (cnt == $past(cnt) - 1'b1));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> (cnt == {CNT_W{1'b1}}));

  // R8
  fall_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !press_pulse);

  // R6
  idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && !blank_active) |=> press_pulse);

endmodule

bind btn_press_qualifier btn_press_qualifier_chk #(.CNT_W(CNT_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .press_pulse  (press_pulse),
  .blank_active (blank_active),
  .rise         (rise_w),
  .fall         (fall_w),
  .cnt          (blank_cnt)
);

// File: tb/test_btn_press_qualifier.sv
module test_btn_press_qualifier;

  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic press_pulse;
  logic blank_active;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  btn_press_qualifier #(.CNT_W(W)) i_btn_press_qualifier (
    .clk          (clk),
    .rst          (rst),
    .btn_raw      (btn_raw),
    .press_pulse  (press_pulse),
    .blank_active (blank_active)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1", press_pulse, 1'b0);
    check("R1", blank_active, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", press_pulse, 1'b0);
    check("R1", blank_active, 1'b0);
    settle(3);

    // R2 / R3: idle press latency and single-cycle width
    btn_raw = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check("R2_R3", press_pulse, (i == 3));
    end
    // R3: held button gives nothing more
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R3", press_pulse, 1'b0);
    end

    // R4 / R8: window length after a single release
    btn_raw = 1'b0;
    for (int i = 1; i <= M + 6; i++) begin
      @(negedge clk);
      check("R4", blank_active, (i >= 3 && i <= M + 2));
      check("R8", press_pulse, 1'b0);
    end

    // R7 / R5: release, short contact, release again inside the window
    btn_raw = 1'b1;
    settle(M + 10);
    btn_raw = 1'b0;
    for (int i = 1; i <= M + 12; i++) begin
      @(negedge clk);
      check("R7", blank_active, (i >= 3 && i <= M + 8));
      check("R5", press_pulse, 1'b0);
      if (i == 2) btn_raw = 1'b1;
      if (i == 6) btn_raw = 1'b0;
    end

    // R6 / R5: sweep the release-to-press spacing
    for (int d = 1; d <= M + 5; d++) begin
      int pulses;
      btn_raw = 1'b1;
      settle(M + 10);
      btn_raw = 1'b0;
      settle(d);
      btn_raw = 1'b1;
      pulses = 0;
      for (int i = 0; i < M + 10; i++) begin
        @(negedge clk);
        if (press_pulse) pulses++;
      end
      check_int((d >= M + 1) ? "R6" : "R5", pulses, (d >= M + 1) ? 1 : 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule